// File: doc/BRIEF.md
# Dual-Organisation Static RAM Model

This block is a synthesizable functional model of an asynchronous static RAM whose organisation is set by a strap input. With the strap high the array is a word-wide memory. Two lane strobes, both active low, pick the low and the high byte lane of each access. With the strap low the same storage becomes a byte-wide memory. An extra low-order address bit then selects which half of a word is accessed, and all data moves on bits 7:0 only.

Access is gated by two chip enables of opposite polarity. It is further steered by an active-low write enable and an active-low output enable. The bidirectional bus is split into a data input vector, a data output vector and one drive-enable bit per byte lane. A pad ring or a board-level model can combine these into tri-state pins. Reads are combinational from the address and the controls. A write is captured on a rising edge of the model clock while the write condition holds at that edge. The depth is a parameter, so a bench can run the model on a small array.

Top module: `dualwidth_sram`

## Requirements
- R1: In word mode (`org_word_i`=1) each of the 2^ADDR_W values of `addr_i` names its own 2·LANE_W-bit word. A word written at one address reads back unchanged, and writes to other addresses do not alter it.
- R2: The chip is selected only when `ce_n_i`=0 and `ce_i`=1. Otherwise `d_oe_o` is 0 and no write takes place, whatever the other controls are.
- R3: In word mode, with both `lb_n_i` and `ub_n_i` high, the chip counts as deselected: `d_oe_o` is 0 and no lane is written.
- R4: A word-mode read (selected, `we_n_i`=1, `oe_n_i`=0) sets `d_oe_o[0]` exactly when `lb_n_i`=0 and `d_oe_o[1]` exactly when `ub_n_i`=0. Each driven lane carries the stored byte of that lane.
- R5: A word-mode write (selected, `we_n_i`=0) stores `d_i[7:0]` when `lb_n_i`=0 and `d_i[15:8]` when `ub_n_i`=0, at any level of `oe_n_i`. A lane whose strobe is high keeps its old content, and `d_oe_o` is 0 while the write is applied.
- R6: In byte mode (`org_word_i`=0) the byte address is {`addr_i`,`addr_lsb_i`}. `addr_lsb_i`=0 selects the low lane of word `addr_i` and 1 selects its high lane. Data moves on `d_i[7:0]` / `d_o[7:0]` only, the lane strobes are ignored, `d_i[15:8]` is ignored and `d_oe_o[1]` stays 0.
- R7: When selected with `we_n_i`=1 and `oe_n_i`=1 the outputs are disabled: `d_oe_o` is 0.
- R8: The bits of `d_o` belonging to a lane whose drive-enable bit is 0 are all zero.
- R9: Storage changes only on a rising edge of `clk_i` at which the write condition holds. A write pulse that starts and ends between two rising edges leaves the content unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Model clock; writes are captured on its rising edge |
| org_word_i | input | 1 | Organisation strap: 1 word-wide, 0 byte-wide |
| ce_n_i | input | 1 | Chip enable, active low |
| ce_i | input | 1 | Chip enable, active high |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| lb_n_i | input | 1 | Low byte lane strobe, active low (word mode) |
| ub_n_i | input | 1 | High byte lane strobe, active low (word mode) |
| addr_i | input | ADDR_W | Word address |
| addr_lsb_i | input | 1 | Half-word select, used in byte mode only |
| d_i | input | 2·LANE_W | Write data |
| d_o | output | 2·LANE_W | Read data, zero on undriven lanes |
| d_oe_o | output | 2 | Per-lane drive enable, bit 0 low lane |

## Verification
The checker assumes that the controls are stable when they are sampled at the rising clock edge. The enables, strobes and strap are therefore treated as level inputs whose combinational effect is settled by that edge. The bench keeps to this: it changes every input on the falling edge, or in a window that lies wholly between two rising edges. Contents are always read back on settled inputs, half a period away from a write edge. The bench fills each location before it reads it, so no check depends on the content of an unwritten cell.

// File: rtl/sram_pkg.sv
package sram_pkg;

   localparam int LANE_CNT = 2;

   typedef enum logic [1:0] {
      ACC_IDLE,
      ACC_HOLD,
      ACC_READ,
      ACC_WRITE
   } acc_mode_e;

endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
   import sram_pkg::*;
(
   input  logic                org_word_i,
   input  logic                ce_n_i,
   input  logic                ce_i,
   input  logic                we_n_i,
   input  logic                oe_n_i,
   input  logic                lb_n_i,
   input  logic                ub_n_i,
   input  logic                addr_lsb_i,
   output logic [LANE_CNT-1:0] lane_wr_o,
   output logic [LANE_CNT-1:0] lane_drv_o
);

   acc_mode_e             mode;
   logic                  chip_on;
   logic                  strobe_any;
   logic [LANE_CNT-1:0]   lane_pick;

   always_comb begin
      chip_on    = !ce_n_i && ce_i;
      // lane strobes only matter for selection in word mode
      strobe_any = org_word_i ? !(lb_n_i && ub_n_i) : 1'b1;

      if (!(chip_on && strobe_any)) begin
         mode = ACC_IDLE;
      end else if (!we_n_i) begin
         mode = ACC_WRITE;
      end else if (!oe_n_i) begin
         mode = ACC_READ;
      end else begin
         mode = ACC_HOLD;
      end

      lane_pick  = org_word_i ? {!ub_n_i, !lb_n_i} : {addr_lsb_i, !addr_lsb_i};
      lane_wr_o  = (mode == ACC_WRITE) ? lane_pick : '0;
      lane_drv_o = (mode == ACC_READ) ? (org_word_i ? lane_pick : 2'b01) : '0;
   end

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 8
) (
   input  logic              clk_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LANE_W-1:0] wdata_i,
   output logic [LANE_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk_i) begin
      if (wr_en_i) begin
         cells[addr_i] <= wdata_i;
      end
   end

   assign rdata_o = cells[addr_i];

endmodule

// File: rtl/dualwidth_sram.sv
module dualwidth_sram
   import sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 8
) (
   input  logic                       clk_i,
   input  logic                       org_word_i,
   input  logic                       ce_n_i,
   input  logic                       ce_i,
   input  logic                       we_n_i,
   input  logic                       oe_n_i,
   input  logic                       lb_n_i,
   input  logic                       ub_n_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic                       addr_lsb_i,
   input  logic [LANE_CNT*LANE_W-1:0] d_i,
   output logic [LANE_CNT*LANE_W-1:0] d_o,
   output logic [LANE_CNT-1:0]        d_oe_o
);

   localparam int DATA_W = LANE_CNT * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("dualwidth_sram: ADDR_W must lie in 1..12");
   end
   if (LANE_W < 1 || LANE_W > 32) begin : g_bad_lane_w
      $error("dualwidth_sram: LANE_W must lie in 1..32");
   end
   if (DATA_W != 2 * LANE_W) begin : g_bad_lanes
      $error("dualwidth_sram: exactly two byte lanes are supported");
   end

   logic [LANE_CNT-1:0] lane_wr;
   logic [LANE_CNT-1:0] lane_drv;
   logic [LANE_W-1:0]   lane_rd [LANE_CNT];

   sram_mode_dec u_dec (
      .org_word_i (org_word_i),
      .ce_n_i     (ce_n_i),
      .ce_i       (ce_i),
      .we_n_i     (we_n_i),
      .oe_n_i     (oe_n_i),
      .lb_n_i     (lb_n_i),
      .ub_n_i     (ub_n_i),
      .addr_lsb_i (addr_lsb_i),
      .lane_wr_o  (lane_wr),
      .lane_drv_o (lane_drv)
   );

   for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
      logic [LANE_W-1:0] wdata;
      logic [LANE_W-1:0] src;

      // byte mode feeds every lane from the low data bits
      assign wdata = (g == 0 || org_word_i) ? d_i[g*LANE_W +: LANE_W]
                                            : d_i[LANE_W-1:0];

      sram_lane_bank #(
         .ADDR_W (ADDR_W),
         .LANE_W (LANE_W)
      ) u_bank (
         .clk_i   (clk_i),
         .wr_en_i (lane_wr[g]),
         .addr_i  (addr_i),
         .wdata_i (wdata),
         .rdata_o (lane_rd[g])
      );

      if (g == 0) begin : g_low_src
         assign src = (!org_word_i && addr_lsb_i) ? lane_rd[1] : lane_rd[0];
      end else begin : g_high_src
         assign src = lane_rd[g];
      end

      assign d_o[g*LANE_W +: LANE_W] = lane_drv[g] ? src : '0;
   end

   assign d_oe_o = lane_drv;

endmodule

// File: rtl/sram_checker.sv
module sram_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk_i,
   input logic              org_word_i,
   input logic              ce_n_i,
   input logic              ce_i,
   input logic              we_n_i,
   input logic              oe_n_i,
   input logic              lb_n_i,
   input logic              ub_n_i,
   input logic [DATA_W-1:0] d_o,
   input logic [1:0]        d_oe_o
);

   localparam int HALF = DATA_W / 2;

   logic armed = 1'b0;
   always_ff @(posedge clk_i) armed <= 1'b1;

   // R2: either enable inactive keeps both lanes quiet
   a_r2_deselect_quiet: assert property (@(posedge clk_i) disable iff (!armed)
      (ce_n_i || !ce_i) |-> (d_oe_o == 2'b00));

   // R3: both strobes high in word mode deselects
   a_r3_strobes_off: assert property (@(posedge clk_i) disable iff (!armed)
      (org_word_i && lb_n_i && ub_n_i) |-> (d_oe_o == 2'b00));

   // R4: word read drives exactly the strobed lanes
   a_r4_read_lanes: assert property (@(posedge clk_i) disable iff (!armed)
      (org_word_i && !ce_n_i && ce_i && we_n_i && !oe_n_i)
      |-> (d_oe_o == {!ub_n_i, !lb_n_i}));

   // R5: no lane drives while a write is applied
   a_r5_write_quiet: assert property (@(posedge clk_i) disable iff (!armed)
      !we_n_i |-> (d_oe_o == 2'b00));

   // R6: the high lane never drives in byte mode
   a_r6_byte_high_off: assert property (@(posedge clk_i) disable iff (!armed)
      !org_word_i |-> !d_oe_o[1]);

   // R7: output disable
   a_r7_output_off: assert property (@(posedge clk_i) disable iff (!armed)
      (we_n_i && oe_n_i) |-> (d_oe_o == 2'b00));

   // R8: undriven lanes read as zero
   a_r8_low_zero: assert property (@(posedge clk_i) disable iff (!armed)
      !d_oe_o[0] |-> (d_o[HALF-1:0] == '0));
   a_r8_high_zero: assert property (@(posedge clk_i) disable iff (!armed)
      !d_oe_o[1] |-> (d_o[DATA_W-1:HALF] == '0));

endmodule

bind dualwidth_sram sram_checker #(
   .DATA_W (DATA_W)
) u_sram_chk (
   .clk_i      (clk_i),
   .org_word_i (org_word_i),
   .ce_n_i     (ce_n_i),
   .ce_i       (ce_i),
   .we_n_i     (we_n_i),
   .oe_n_i     (oe_n_i),
   .lb_n_i     (lb_n_i),
   .ub_n_i     (ub_n_i),
   .d_o        (d_o),
   .d_oe_o     (d_oe_o)
);

// File: tb/dualwidth_sram_tb.sv
module dualwidth_sram_tb_top;

   localparam int AW    = 4;
   localparam int WORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          org_word, ce_n, ce, we_n, oe_n, lb_n, ub_n, a_lsb;
   logic [AW-1:0] addr;
   logic [15:0]   din, dout;
   logic [1:0]    doe;

   logic [7:0] ref_lo [WORDS];
   logic [7:0] ref_hi [WORDS];

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   dualwidth_sram #(.ADDR_W(AW), .LANE_W(8)) dut_i (
      .clk_i(clk), .org_word_i(org_word), .ce_n_i(ce_n), .ce_i(ce),
      .we_n_i(we_n), .oe_n_i(oe_n), .lb_n_i(lb_n), .ub_n_i(ub_n),
      .addr_i(addr), .addr_lsb_i(a_lsb), .d_i(din), .d_o(dout), .d_oe_o(doe)
   );

   function automatic logic [15:0] pat(input int a, input int k);
      return 16'(a * 507 + k * 4321 + 23100);
   endfunction

   task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic setup(input logic cn, input logic cp, input logic wn, input logic on,
                        input logic ln, input logic un, input logic [AW-1:0] a,
                        input logic l, input logic [15:0] d);
      ce_n = cn; ce = cp; we_n = wn; oe_n = on; lb_n = ln; ub_n = un;
      addr = a; a_lsb = l; din = d;
   endtask

   task automatic idle();
      ce_n = 1'b1; ce = 1'b0; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
   endtask

   task automatic wr(input logic cn, input logic cp, input logic on, input logic ln,
                     input logic un, input logic [AW-1:0] a, input logic l,
                     input logic [15:0] d);
      @(negedge clk);
      setup(cn, cp, 1'b0, on, ln, un, a, l, d);
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic rd_chk(input string req, input logic ln, input logic un,
                         input logic [AW-1:0] a, input logic l, input logic [17:0] exp);
      @(negedge clk);
      setup(1'b0, 1'b1, 1'b1, 1'b0, ln, un, a, l, 16'h0);
      #5;
      check(req, {doe, dout}, exp);
      idle();
   endtask

   task automatic read_all(input string req);
      for (int a = 0; a < WORDS; a++)
         rd_chk(req, 1'b0, 1'b0, AW'(a), 1'b0, {2'b11, ref_hi[a], ref_lo[a]});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      org_word = 1'b1;
      idle();
      addr = '0; a_lsb = 1'b0; din = '0;
      repeat (2) @(negedge clk);
      #5 check("R2 idle", {doe, dout}, 18'h0);

      // R1 R5: fill every word, output enable alternating
      for (int a = 0; a < WORDS; a++) begin
         wr(1'b0, 1'b1, a[0], 1'b0, 1'b0, AW'(a), 1'b0, pat(a, 0));
         {ref_hi[a], ref_lo[a]} = pat(a, 0);
      end
      read_all("R1 word fill");

      // R5 R4 R8: single-lane writes and reads
      for (int a = 0; a < WORDS; a++) begin
         wr(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, AW'(a), 1'b0, pat(a, 1));
         ref_lo[a] = pat(a, 1) & 16'hff;
         rd_chk("R5 low lane only", 1'b0, 1'b0, AW'(a), 1'b0, {2'b11, ref_hi[a], ref_lo[a]});
         wr(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AW'(a), 1'b0, pat(a, 2));
         ref_hi[a] = pat(a, 2) >> 8;
         rd_chk("R4 low strobe read", 1'b0, 1'b1, AW'(a), 1'b0, {2'b01, 8'h00, ref_lo[a]});
         rd_chk("R8 high strobe read", 1'b1, 1'b0, AW'(a), 1'b0, {2'b10, ref_hi[a], 8'h00});
      end

      // R3: both strobes high
      for (int a = 0; a < WORDS; a++) begin
         wr(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, AW'(a), 1'b0, pat(a, 3));
         rd_chk("R3 read no strobe", 1'b1, 1'b1, AW'(a), 1'b0, 18'h0);
      end
      read_all("R3 unchanged");

      // R2: each enable inactive in turn
      for (int a = 0; a < WORDS; a++) begin
         wr(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, AW'(a), 1'b0, pat(a, 4));
         wr(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(a), 1'b0, pat(a, 5));
      end
      read_all("R2 unchanged");
      @(negedge clk);
      setup(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
      #5 check("R2 read low enable off", {doe, dout}, 18'h0);
      setup(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
      #2 check("R2 read high enable off", {doe, dout}, 18'h0);
      idle();

      // R7: output disable
      for (int a = 0; a < WORDS; a++) begin
         @(negedge clk);
         setup(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, AW'(a), 1'b0, '0);
         #5 check("R7 output disable", {doe, dout}, 18'h0);
         idle();
      end

      // R9 R5: write pulse entirely between rising edges
      for (int a = 0; a < WORDS; a++) begin
         @(negedge clk);
         setup(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, AW'(a), 1'b0, ~pat(a, 0));
         #3 check("R5 quiet during write", {doe, dout}, 18'h0);
         #3 we_n = 1'b1;
         idle();
      end
      read_all("R9 short pulse ignored");

      // R6: byte mode, strobes high and upper data ignored
      org_word = 1'b0;
      for (int a = 0; a < WORDS; a++) begin
         for (int l = 0; l < 2; l++) begin
            logic [7:0] b;
            b = 8'(pat(a, 6 + l));
            wr(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, AW'(a), l[0], {~b, b});
            if (l == 0) ref_lo[a] = b;
            else        ref_hi[a] = b;
         end
      end
      for (int a = 0; a < WORDS; a++) begin
         rd_chk("R6 byte read low", 1'b1, 1'b1, AW'(a), 1'b0, {2'b01, 8'h00, ref_lo[a]});
         rd_chk("R6 byte read high", 1'b0, 1'b1, AW'(a), 1'b1, {2'b01, 8'h00, ref_hi[a]});
      end
      org_word = 1'b1;
      read_all("R6 byte to word view");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule